// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer Unit

This block holds three separate down-counting timer channels behind a small memory-mapped register bus. Software gives each channel a reload value, a live count and a control word. A shared run register lets each channel count or hold. A running channel steps down by one at a rate set by its control word: the peripheral clock divided by 4, 16, 64, 256 or 1024. When a tick arrives while the count is zero, the channel loads its reload value and raises a sticky underflow flag.

Each channel drives its own level interrupt. The interrupt is high while the channel's flag and its enable bit are both set. Software can clear the flag but can never set it. A control write that changes either bit therefore raises or drops the interrupt in the next cycle.

Writes take effect at the clock edge where `bus_wr_en` is high. Reads are combinational from `bus_addr`. Channel n has its reload register at byte 0x04+12n, its count at 0x08+12n and its control at 0x0C+12n, so the control registers are 12 bytes apart. The run register is at 0x00.

Top module: `tick_timer_unit`

## Requirements
- R1: After reset, every count and reload register reads all-ones, every control register and the run register read zero, and all interrupts are low.
- R2: The run register is at 0x00 and holds bit n for channel n in bits 2:0. Channel n has its reload register at 0x04+12n, its count at 0x08+12n and its 16-bit control word at 0x0C+12n. All of these read back what was written, except the flag bit and run bits 31:3, which read zero.
- R3: A channel whose run bit is 0 holds its count. A channel whose run bit is 1 decrements by one per tick of its divided clock.
- R4: Control bits 2:0 select the divider: 0→4, 1→16, 2→64, 3→256, 4→1024. The first decrement comes exactly N cycles after the edge that starts the channel or writes its control. Values 5 to 7 stop the channel from counting.
- R5: A tick that finds the count at zero loads the reload value into the count and sets the underflow flag (control bit 8) in the same edge.
- R6: A control write can never set bit 8. Writing 1 there while the flag is 0 reads back 0.
- R7: While the flag is set, writing 0 to bit 8 clears it, and writing 1 keeps it set.
- R8: A channel's interrupt is high exactly when bit 8 and its enable (control bit 5) are both 1. It follows a control write by one cycle.
- R9: When an underflow and a control write that clears the flag happen on the same edge, the flag ends up set.
- R10: Channels count independently, each at its own divider and run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 3 | Per-channel level interrupt |

## Verification
The assertions assume a write strobe is only meaningful with a stable address and data at the edge, and that addresses outside the map are harmless. The stimulus changes bus signals only on falling edges and writes only mapped addresses. The hold and reload properties leave out the cycles in which software writes the count itself, because a count write overrides the counter. The stimulus makes the simultaneous underflow-and-clear case happen on purpose, by placing a control write exactly on the tick edge.

// File: rtl/timer_pkg.sv
// Shared constants and helpers for the timer unit: the register map
// offsets, the control field positions and the divider decode.
package timer_pkg;
    localparam int START_ADDR = 0;
    localparam int CH_BASE    = 4;
    localparam int CH_STRIDE  = 12;
    localparam int CONST_OFS  = 0;
    localparam int COUNT_OFS  = 4;
    localparam int CTRL_OFS   = 8;
    localparam int CTRL_W     = 16;
    localparam int FLAG_BIT   = 8;
    localparam int IE_BIT     = 5;
    localparam int PRE_W      = 10;

    // Low-bit mask whose all-ones value marks one tick of the chosen divider.
    function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] sel);
        case (sel)
            3'd0:    div_mask = PRE_W'(10'h003);
            3'd1:    div_mask = PRE_W'(10'h00F);
            3'd2:    div_mask = PRE_W'(10'h03F);
            3'd3:    div_mask = PRE_W'(10'h0FF);
            3'd4:    div_mask = PRE_W'(10'h3FF);
            default: div_mask = '0;
        endcase
    endfunction

    // Reports whether a select value names a real divider.
    function automatic logic sel_valid(input logic [2:0] sel);
        sel_valid = (sel <= 3'd4);
    endfunction
endpackage

// File: rtl/timer_prescaler.sv
// Per-channel prescaler. It counts cycles while the channel runs and
// emits one tick every N cycles for the selected divider. It clears when
// the channel stops or its control is rewritten, so the phase is always
// known. Assumes sel is stable except on restart cycles.
module timer_prescaler
    import timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // Divider mask for the current select.
    assign mask = div_mask(sel);

    // Tick when the masked low bits are all ones.
    assign tick = run && sel_valid(sel) && ((pre_q & mask) == mask);

    // Free-running phase counter, cleared while stopped or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) pre_q <= '0;
        else                           pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/timer_channel.sv
// One timer channel: reload, count and control registers. Handles
// decrement and reload, the sticky underflow flag (software may only
// clear it, and hardware set wins), and the level interrupt.
// Assumes at most one register write strobe per cycle.
module timer_channel
    import timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_const,
    input  logic              wr_count,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] const_q,
    output logic [DATA_W-1:0] count_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              uf,
    output logic              irq
);
    logic [CTRL_W-1:0] ctrl_nxt;

    // Underflow event: a tick that finds the count at zero.
    assign uf = tick && (count_q == '0);

    // Level interrupt from the flag and its enable.
    assign irq = ctrl_q[FLAG_BIT] && ctrl_q[IE_BIT];

    // Next control value: mask the flag on writes, then let hardware set it.
    always_comb begin
        ctrl_nxt = ctrl_q;
        if (wr_ctrl) begin
            ctrl_nxt           = wdata[CTRL_W-1:0];
            ctrl_nxt[FLAG_BIT] = ctrl_q[FLAG_BIT] & wdata[FLAG_BIT];
        end
        if (uf) ctrl_nxt[FLAG_BIT] = 1'b1;
    end

    // Control register update.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_nxt;
    end

    // Reload register update.
    always_ff @(posedge clk) begin
        if (!rst_n)        const_q <= '1;
        else if (wr_const) const_q <= wdata;
    end

    // Counter: a software write wins, otherwise decrement or reload on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '1;
        else if (wr_count) count_q <= wdata;
        else if (tick)     count_q <= (count_q == '0) ? const_q : count_q - 1'b1;
    end
endmodule

// File: rtl/timer_regbus.sv
// Register bus front end: decodes write strobes per channel, holds the
// run register and builds the combinational read data.
// Assumes the address is stable while bus_wr_en is high.
module timer_regbus
    import timer_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_wr_en,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  const_in,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  count_in,
    input  logic [NUM_CH-1:0][CTRL_W-1:0]  ctrl_in,
    output logic [NUM_CH-1:0]              wr_const,
    output logic [NUM_CH-1:0]              wr_count,
    output logic [NUM_CH-1:0]              wr_ctrl,
    output logic [NUM_CH-1:0]              start_q,
    output logic [DATA_W-1:0]              bus_rdata
);
    localparam logic [ADDR_W-1:0] A_START = ADDR_W'(START_ADDR);

    // Per-channel write decode.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        localparam logic [ADDR_W-1:0] A_CONST = ADDR_W'(CH_BASE + CH_STRIDE*i + CONST_OFS);
        localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(CH_BASE + CH_STRIDE*i + COUNT_OFS);
        localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CH_BASE + CH_STRIDE*i + CTRL_OFS);
        assign wr_const[i] = bus_wr_en && (bus_addr == A_CONST);
        assign wr_count[i] = bus_wr_en && (bus_addr == A_COUNT);
        assign wr_ctrl[i]  = bus_wr_en && (bus_addr == A_CTRL);
    end

    // Run register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   start_q <= '0;
        else if (bus_wr_en && (bus_addr == A_START)) start_q <= bus_wdata[NUM_CH-1:0];
    end

    // Read data mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_START) bus_rdata[NUM_CH-1:0] = start_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*i + CONST_OFS)) bus_rdata = const_in[i];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*i + COUNT_OFS)) bus_rdata = count_in[i];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE*i + CTRL_OFS))  bus_rdata = DATA_W'(ctrl_in[i]);
        end
    end
endmodule

// File: rtl/tick_timer_unit.sv
// Top of the multi-channel timer unit: one register front end, plus one
// prescaler and one channel per timer. Assumes a single clock domain
// and a synchronous active-low reset.
module tick_timer_unit
    import timer_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0][DATA_W-1:0] const_flat;
    logic [NUM_CH-1:0][DATA_W-1:0] count_flat;
    logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_flat;
    logic [NUM_CH-1:0]             wr_const, wr_count, wr_ctrl;
    logic [NUM_CH-1:0]             start_q, tick_vec, uf_vec, flag_vec;

    timer_regbus #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .const_in(const_flat), .count_in(count_flat),
        .ctrl_in(ctrl_flat), .wr_const(wr_const), .wr_count(wr_count),
        .wr_ctrl(wr_ctrl), .start_q(start_q), .bus_rdata(bus_rdata)
    );

    // One prescaler and one counter per channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        timer_prescaler u_pre (
            .clk(clk), .rst_n(rst_n), .run(start_q[i]), .restart(wr_ctrl[i]),
            .sel(ctrl_flat[i][2:0]), .tick(tick_vec[i])
        );
        timer_channel #(.DATA_W(DATA_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .tick(tick_vec[i]),
            .wr_const(wr_const[i]), .wr_count(wr_count[i]), .wr_ctrl(wr_ctrl[i]),
            .wdata(bus_wdata), .const_q(const_flat[i]), .count_q(count_flat[i]),
            .ctrl_q(ctrl_flat[i]), .uf(uf_vec[i]), .irq(irq[i])
        );
        assign flag_vec[i] = ctrl_flat[i][FLAG_BIT];
    end
endmodule

// File: rtl/timer_unit_chk.sv
// Checker for the timer unit, bound to the top. It relates the flag,
// the interrupt and the counters to bus writes and underflow events.
module timer_unit_chk
    import timer_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [DATA_W-1:0]             bus_wdata,
    input logic [NUM_CH-1:0]             irq,
    input logic [NUM_CH-1:0]             flag_vec,
    input logic [NUM_CH-1:0]             uf_vec,
    input logic [NUM_CH-1:0]             start_q,
    input logic [NUM_CH-1:0]             wr_count,
    input logic [NUM_CH-1:0]             wr_ctrl,
    input logic [NUM_CH-1:0][DATA_W-1:0] count_flat,
    input logic [NUM_CH-1:0][DATA_W-1:0] const_flat
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_flag_only_hw_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_vec[i]) |-> $past(uf_vec[i]));
        assert_hw_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            uf_vec[i] |=> flag_vec[i]);
        assert_irq_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_ctrl[i] && !bus_wdata[IE_BIT]) |=> !irq[i]);
        assert_irq_raises_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_ctrl[i] && bus_wdata[IE_BIT] && bus_wdata[FLAG_BIT] && flag_vec[i]) |=> irq[i]);
        assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!start_q[i] && !wr_count[i]) |=> $stable(count_flat[i]));
        assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (uf_vec[i] && !wr_count[i]) |=> (count_flat[i] == $past(const_flat[i])));
    end
endmodule

bind tick_timer_unit timer_unit_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .irq(irq),
    .flag_vec(flag_vec), .uf_vec(uf_vec), .start_q(start_q),
    .wr_count(wr_count), .wr_ctrl(wr_ctrl),
    .count_flat(count_flat), .const_flat(const_flat)
);

// File: tb/tb_tick_timer_unit.sv
// Directed bench for the timer unit: one task per scenario.
module tb_tick_timer_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;
    int checks = 0;
    int fails  = 0;

    tick_timer_unit dut (.clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    always #5 clk = ~clk;

    function automatic logic [5:0] a_const(int ch); return 6'(4 + 12*ch); endfunction
    function automatic logic [5:0] a_count(int ch); return 6'(8 + 12*ch); endfunction
    function automatic logic [5:0] a_ctrl(int ch);  return 6'(12 + 12*ch); endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(posedge clk);
        #1 bus_wr_en = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        for (int c = 0; c < 3; c++) begin
            rd(a_const(c), d); chk("R1 reload", d, 32'hFFFF_FFFF);
            rd(a_count(c), d); chk("R1 count", d, 32'hFFFF_FFFF);
            rd(a_ctrl(c), d);  chk("R1 ctrl", d, 32'h0);
        end
        rd(6'h00, d); chk("R1 run", d, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        do_reset();
        for (int c = 0; c < 3; c++) begin
            wr(a_const(c), 32'hA000_0000 + 32'(c));
            wr(a_count(c), 32'hB000_0000 + 32'(c));
            wr(a_ctrl(c), 32'h0000_FE20 | 32'(c));
        end
        for (int c = 0; c < 3; c++) begin
            rd(a_const(c), d); chk("R2 reload map", d, 32'hA000_0000 + 32'(c));
            rd(a_count(c), d); chk("R2 count map", d, 32'hB000_0000 + 32'(c));
            rd(a_ctrl(c), d);  chk("R2 ctrl map", d, 32'h0000_FE20 | 32'(c));
        end
        wr(6'h00, 32'hFFFF_FFF8);
        rd(6'h00, d); chk("R2 run upper bits", d, 32'h0);
    endtask

    task automatic t_divider(logic [2:0] sel, int n);
        logic [31:0] d;
        do_reset();
        wr(a_const(0), 32'd1000);
        wr(a_count(0), 32'd77);
        wr(a_ctrl(0), 32'(sel));
        wr(6'h00, 32'h1);
        repeat (n-1) @(posedge clk);
        @(negedge clk);
        rd(a_count(0), d); chk("R4 no early step", d, 32'd77);
        @(posedge clk); @(negedge clk);
        rd(a_count(0), d); chk("R4 step at N", d, 32'd76);
        repeat (n) @(posedge clk);
        @(negedge clk);
        rd(a_count(0), d); chk("R3 second step", d, 32'd75);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        do_reset();
        wr(a_count(1), 32'd9);
        wr(a_ctrl(1), 32'h5);
        wr(6'h00, 32'h2);
        repeat (2000) @(posedge clk);
        @(negedge clk);
        rd(a_count(1), d); chk("R4 reserved select", d, 32'd9);
    endtask

    task automatic t_hold();
        logic [31:0] d, held;
        do_reset();
        wr(a_count(2), 32'd50);
        wr(a_ctrl(2), 32'h0);
        wr(6'h00, 32'h4);
        repeat (20) @(posedge clk);
        wr(6'h00, 32'h0);
        @(negedge clk);
        rd(a_count(2), held);
        chk("R3 counted while running", 32'(held < 32'd50), 32'h1);
        repeat (40) @(posedge clk);
        @(negedge clk);
        rd(a_count(2), d); chk("R3 hold when stopped", d, held);
    endtask

    task automatic t_underflow_flags();
        logic [31:0] d;
        do_reset();
        wr(a_const(0), 32'd5);
        wr(a_count(0), 32'd1);
        wr(a_ctrl(0), 32'h0);
        wr(6'h00, 32'h1);
        repeat (8) @(posedge clk);
        #1 bus_wr_en = 1'b0;
        @(negedge clk);
        bus_addr = 6'h00; bus_wdata = 32'h0; bus_wr_en = 1'b1;
        @(posedge clk); #1 bus_wr_en = 1'b0;
        rd(a_count(0), d); chk("R5 reload value", d, 32'd5);
        rd(a_ctrl(0), d);  chk("R5 flag set", d, 32'h0100);
        chk("R8 no irq without enable", 32'(irq), 32'h0);
        wr(a_ctrl(0), 32'h0120);
        @(negedge clk);
        chk("R8 irq on enable", 32'(irq), 32'h1);
        rd(a_ctrl(0), d); chk("R7 write 1 keeps flag", d, 32'h0120);
        wr(a_ctrl(0), 32'h0100);
        @(negedge clk);
        chk("R8 irq drops on disable", 32'(irq), 32'h0);
        wr(a_ctrl(0), 32'h0120);
        wr(a_ctrl(0), 32'h0020);
        @(negedge clk);
        rd(a_ctrl(0), d); chk("R7 write 0 clears flag", d, 32'h0020);
        chk("R8 irq drops on clear", 32'(irq), 32'h0);
    endtask

    task automatic t_no_sw_set();
        logic [31:0] d;
        do_reset();
        wr(a_ctrl(1), 32'h0120);
        @(negedge clk);
        rd(a_ctrl(1), d); chk("R6 flag not settable", d, 32'h0020);
        chk("R6 irq stays low", 32'(irq), 32'h0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        do_reset();
        wr(a_const(0), 32'd7);
        wr(a_count(0), 32'd0);
        wr(a_ctrl(0), 32'h0);
        wr(6'h00, 32'h1);
        repeat (3) @(posedge clk);
        wr(a_ctrl(0), 32'h0);
        @(negedge clk);
        rd(a_ctrl(0), d);  chk("R9 hw set wins", d, 32'h0100);
        rd(a_count(0), d); chk("R9 reload on tie", d, 32'd7);
    endtask

    task automatic t_independent();
        logic [31:0] d;
        do_reset();
        for (int c = 0; c < 3; c++) wr(a_count(c), 32'd100);
        wr(a_ctrl(0), 32'h0);
        wr(a_ctrl(1), 32'h1);
        wr(6'h00, 32'h3);
        repeat (16) @(posedge clk);
        @(negedge clk);
        rd(a_count(0), d); chk("R10 ch0 div4", d, 32'd96);
        rd(a_count(1), d); chk("R10 ch1 div16", d, 32'd99);
        rd(a_count(2), d); chk("R10 ch2 stopped", d, 32'd100);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_regmap();
        t_divider(3'd0, 4);
        t_divider(3'd1, 16);
        t_divider(3'd2, 64);
        t_divider(3'd3, 256);
        t_divider(3'd4, 1024);
        t_reserved();
        t_hold();
        t_underflow_flags();
        t_no_sw_set();
        t_priority();
        t_independent();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule